// File: doc/BRIEF.md
# Software-Generated Interrupt Dispatcher

This block turns a single write to a software-interrupt request register into pending state on a chosen group of processor interfaces. The write word carries three things. The first is an interrupt ID in the range 0 to 15; that range is set aside for processor-to-processor interrupts. The second is an explicit list of target interfaces. The third is a selector that says how the targets are picked. The requester's own interface index comes in on a separate input with the write, so that the selector can include or exclude the requester.

One cycle after a write, the block presents a per-target strobe and the ID it belongs to. It also reports which of those targets had that ID newly raised rather than already pending. Each target holds a 16-bit sticky pending vector. A bit stays set until that target's own clear input removes it. A typical use is a set of CPU interface front ends: each one reads its pending vector and clears a bit once it has taken the interrupt.

Top module: `sgi_dispatch`

## Requirements
- R1: After reset, every pending bit, every set strobe and every fresh strobe is 0.
- R2: A write with selector bits [25:24] = 00 sets, one cycle later, the strobe of exactly the interfaces whose bits are 1 in list bits [23:16] (bit 16 is interface 0).
- R3: A write with selector 01 strobes every interface except the one given on `wr_src`, whatever the list bits hold.
- R4: A write with selector 10 strobes only the interface given on `wr_src`, whatever the list bits hold.
- R5: A write with selector 11 produces no strobe and changes no pending bit.
- R6: A write with selector 00 and an all-zero list produces no strobe and changes no pending bit.
- R7: Bits [3:0] select the pending bit and are presented on `set_id`. Bits [15:4] and [31:26] have no effect.
- R8: A pending bit stays set until its target's clear input names it, across any number of other writes.
- R9: A 1 in the clear input for target t, bit i clears that bit at the next edge. When a set for the same bit lands on the same edge, the set wins and the bit ends up 1.
- R10: `fresh_stb` marks only the strobed targets whose selected bit was 0 before the write's edge. Raising an already pending bit again is not reported as fresh.
- R11: The strobes last one cycle. In a cycle after an edge with no write, `set_stb` and `fresh_stb` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Request register write this cycle |
| wr_word | input | 32 | Written word: ID [3:0], list [23:16], selector [25:24] |
| wr_src | input | 3 | Index of the requesting interface |
| clr_bits | input | 128 | Per-target clear masks, target t at [t*16 +: 16] |
| set_stb | output | 8 | One-cycle strobe per target raised by the write |
| set_id | output | 4 | ID carried with `set_stb` |
| fresh_stb | output | 8 | Strobed targets whose bit was newly raised |
| pend_vec | output | 128 | Pending vectors, target t at [t*16 +: 16] |

## Verification
A wrong target decode shows up on `set_stb` in the cycle after the write, and on `pend_vec` in that same cycle. The bench therefore compares both for every write, using its own model of the selector. A pending bit that is lost or stuck does not necessarily cause a wrong strobe. It does appear on `pend_vec` at the next comparison, and on `fresh_stb` when the same ID is raised again. For that reason the bench repeats IDs and mixes clears with writes, including a set and a clear on the same edge.

// File: rtl/sgi_pkg.sv
package sgi_pkg;

  // Field positions inside the written request word
  localparam int unsigned ID_LSB   = 0;
  localparam int unsigned ID_BITS  = 4;
  localparam int unsigned LST_LSB  = 16;
  localparam int unsigned LST_BITS = 8;
  localparam int unsigned SEL_LSB  = 24;

  typedef enum logic [1:0] {
    SEL_LIST   = 2'b00,
    SEL_OTHERS = 2'b01,
    SEL_SELF   = 2'b10,
    SEL_RSVD   = 2'b11
  } sgi_sel_e;

endpackage

// File: rtl/sgi_decode.sv
module sgi_decode
  import sgi_pkg::*;
#(
  parameter int unsigned NT   = 8,
  parameter int unsigned IDW  = 4,
  localparam int unsigned SRCW = (NT > 1) ? $clog2(NT) : 1
) (
  input  logic            wr_valid,
  input  logic [31:0]     wr_word,
  input  logic [SRCW-1:0] wr_src,
  output logic            dec_valid,
  output logic [NT-1:0]   dec_mask,
  output logic [IDW-1:0]  dec_id
);

  // Target selection, kept as a function so the rule reads in one place
  function automatic logic [NT-1:0] pick_targets(
    input sgi_sel_e         sel,
    input logic [NT-1:0]   lst,
    input logic [SRCW-1:0] src
  );
    logic [NT-1:0] me;
    me = NT'(1) << src;
    case (sel)
      SEL_LIST:   pick_targets = lst;
      SEL_OTHERS: pick_targets = ~me;
      SEL_SELF:   pick_targets = me;
      default:    pick_targets = '0;
    endcase
  endfunction

  sgi_sel_e      sel;
  logic [NT-1:0] lst;
  logic [NT-1:0] tgt;

  assign sel       = sgi_sel_e'(wr_word[SEL_LSB +: 2]);
  assign lst       = wr_word[LST_LSB +: NT];
  assign tgt       = pick_targets(sel, lst, wr_src);
  assign dec_mask  = wr_valid ? tgt : '0;
  assign dec_valid = |dec_mask;
  assign dec_id    = wr_word[ID_LSB +: IDW];

endmodule

// File: rtl/sgi_pend_bank.sv
module sgi_pend_bank #(
  parameter int unsigned NID = 16,
  localparam int unsigned IDW = $clog2(NID)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           set_en,
  input  logic [IDW-1:0] set_id,
  input  logic [NID-1:0] clr,
  output logic [NID-1:0] pend,
  output logic           was_pend
);

  logic [NID-1:0] set_bits;

  assign set_bits = set_en ? (NID'(1) << set_id) : '0;
  assign was_pend = pend[set_id];

  // Clear first, then set: a set on the same edge wins
  always_ff @(posedge clk) begin
    if (!rst_n) pend <= '0;
    else        pend <= (pend & ~clr) | set_bits;
  end

endmodule

// File: rtl/sgi_dispatch.sv
module sgi_dispatch
  import sgi_pkg::*;
#(
  parameter int unsigned NT  = 8,
  parameter int unsigned NID = 16,
  localparam int unsigned IDW  = $clog2(NID),
  localparam int unsigned SRCW = (NT > 1) ? $clog2(NT) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  input  logic [31:0]       wr_word,
  input  logic [SRCW-1:0]   wr_src,
  input  logic [NT*NID-1:0] clr_bits,
  output logic [NT-1:0]     set_stb,
  output logic [IDW-1:0]    set_id,
  output logic [NT-1:0]     fresh_stb,
  output logic [NT*NID-1:0] pend_vec
);

  // Named internal events
  logic            dec_valid;
  logic [NT-1:0]   dec_mask;
  logic [IDW-1:0]  dec_id;
  logic [NT-1:0]   old_bit;

  sgi_decode #(.NT(NT), .IDW(IDW)) u_dec (
    .wr_valid (wr_valid),
    .wr_word  (wr_word),
    .wr_src   (wr_src),
    .dec_valid(dec_valid),
    .dec_mask (dec_mask),
    .dec_id   (dec_id)
  );

  for (genvar g = 0; g < NT; g++) begin : g_tgt
    sgi_pend_bank #(.NID(NID)) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_en  (dec_mask[g]),
      .set_id  (dec_id),
      .clr     (clr_bits[g*NID +: NID]),
      .pend    (pend_vec[g*NID +: NID]),
      .was_pend(old_bit[g])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      set_stb   <= '0;
      set_id    <= '0;
      fresh_stb <= '0;
    end else begin
      set_stb   <= dec_mask;
      fresh_stb <= dec_mask & ~old_bit;
      if (dec_valid) set_id <= dec_id;
    end
  end

endmodule

// File: rtl/sgi_dispatch_chk.sv
module sgi_dispatch_chk #(
  parameter int unsigned NT  = 8,
  parameter int unsigned NID = 16,
  localparam int unsigned SRCW = (NT > 1) ? $clog2(NT) : 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_valid,
  input logic [31:0]       wr_word,
  input logic [SRCW-1:0]   wr_src,
  input logic [NT*NID-1:0] clr_bits,
  input logic [NT-1:0]     set_stb,
  input logic [NT-1:0]     fresh_stb,
  input logic [NT*NID-1:0] pend_vec
);

  p_stb_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_valid |=> (set_stb == '0 && fresh_stb == '0));

  p_rsvd_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_word[25:24] == 2'b11) |=> set_stb == '0);

  p_self_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_word[25:24] == 2'b10) |=> set_stb == (NT'(1) << $past(wr_src)));

  p_others_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_word[25:24] == 2'b01) |=> set_stb == ~(NT'(1) << $past(wr_src)));

  p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(pend_vec) & ~$past(clr_bits)) & ~pend_vec) == '0);

  p_fresh_sub_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (fresh_stb & ~set_stb) == '0);

endmodule

bind sgi_dispatch sgi_dispatch_chk #(.NT(NT), .NID(NID)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .wr_valid (wr_valid),
  .wr_word  (wr_word),
  .wr_src   (wr_src),
  .clr_bits (clr_bits),
  .set_stb  (set_stb),
  .fresh_stb(fresh_stb),
  .pend_vec (pend_vec)
);

// File: tb/sgi_dispatch_tb.sv
module sgi_dispatch_tb;

  localparam int NT  = 8;
  localparam int NID = 16;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            wr_valid = 1'b0;
  logic [31:0]     wr_word = '0;
  logic [2:0]      wr_src = '0;
  logic [NT*NID-1:0] clr_bits = '0;
  logic [NT-1:0]   set_stb;
  logic [3:0]      set_id;
  logic [NT-1:0]   fresh_stb;
  logic [NT*NID-1:0] pend_vec;

  always #10 clk = ~clk;

  sgi_dispatch u_dut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_word(wr_word),
    .wr_src(wr_src), .clr_bits(clr_bits), .set_stb(set_stb),
    .set_id(set_id), .fresh_stb(fresh_stb), .pend_vec(pend_vec)
  );

  typedef struct {
    logic [NT-1:0] stb;
    logic [3:0]    id;
    logic [NT-1:0] fresh;
    string         tag;
  } exp_t;

  exp_t exp_q[$];
  logic [NT*NID-1:0] m_pend = '0;
  int n_chk = 0;
  int n_bad = 0;
  logic seen_wr = 1'b0;
  logic mon_on = 1'b0;
  logic done = 1'b0;

  // Model of target selection, written from the requirements
  function automatic logic [NT-1:0] model_tgt(logic [31:0] w, logic [2:0] s);
    logic [NT-1:0] r;
    r = '0;
    if (w[25:24] == 2'b00) r = w[23:16];
    else if (w[25:24] == 2'b01) begin
      for (int i = 0; i < NT; i++) r[i] = (i != int'(s));
    end else if (w[25:24] == 2'b10) r[s] = 1'b1;
    return r;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [127:0] act,
                     input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Driver: presents a write (optionally with clears) and queues the expectation
  task automatic do_write(input logic [31:0] w, input logic [2:0] s,
                          input logic [NT*NID-1:0] clr, input string tag);
    exp_t e;
    logic [NT-1:0] tg;
    tg = model_tgt(w, s);
    e.stb = tg;
    e.id  = w[3:0];
    e.tag = tag;
    for (int t = 0; t < NT; t++) e.fresh[t] = tg[t] & ~m_pend[t*NID + int'(w[3:0])];
    @(negedge clk);
    wr_valid = 1'b1; wr_word = w; wr_src = s; clr_bits = clr;
    exp_q.push_back(e);
    m_pend = m_pend & ~clr;
    for (int t = 0; t < NT; t++) if (tg[t]) m_pend[t*NID + int'(w[3:0])] = 1'b1;
    @(negedge clk);
    wr_valid = 1'b0; wr_word = '0; clr_bits = '0;
  endtask

  task automatic do_clr(input logic [NT*NID-1:0] clr);
    @(negedge clk);
    clr_bits = clr;
    m_pend = m_pend & ~clr;
    @(negedge clk);
    clr_bits = '0;
  endtask

  task automatic chk_pend(input string tag);
    #1;
    chk(pend_vec == m_pend, tag, pend_vec, m_pend);
  endtask

  always @(posedge clk) seen_wr <= wr_valid;

  // Monitor: compares each cycle's strobes against the queue
  always @(negedge clk) begin
    if (mon_on) begin
      if (seen_wr) begin
        exp_t e;
        if (exp_q.size() == 0) begin
          chk(1'b0, "queue underflow", 0, 0);
        end else begin
          e = exp_q.pop_front();
          chk(set_stb == e.stb, {e.tag, " set_stb"}, set_stb, e.stb);
          chk(fresh_stb == e.fresh, {e.tag, " fresh_stb R10"}, fresh_stb, e.fresh);
          if (e.stb != '0) chk(set_id == e.id, {e.tag, " set_id R7"}, set_id, e.id);
        end
      end else begin
        chk(set_stb == '0 && fresh_stb == '0, "R11 idle strobes",
            {set_stb, fresh_stb}, 0);
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(pend_vec == '0, "R1 pend after reset", pend_vec, 0);
    chk(set_stb == '0 && fresh_stb == '0, "R1 strobes after reset", {set_stb, fresh_stb}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    mon_on = 1'b1;

    do_write(32'h0005_0003, 3'd0, '0, "R2 list 05 id3");
    chk_pend("R2 pend");
    do_write(32'h0005_0003, 3'd0, '0, "R10 repeat id3");
    chk_pend("R10 pend");
    do_write(32'h01FF_0007, 3'd2, '0, "R3 others src2");
    chk_pend("R3 pend");
    do_write(32'h0201_000F, 3'd6, '0, "R4 self src6");
    chk_pend("R4 pend");
    do_write(32'h03FF_0001, 3'd0, '0, "R5 reserved");
    chk_pend("R5 pend unchanged");
    do_write(32'h0000_0002, 3'd1, '0, "R6 empty list");
    chk_pend("R6 pend unchanged");
    do_write(32'hFC02_FFF9, 3'd3, '0, "R7 junk bits id9");
    chk_pend("R7 pend");
    repeat (3) @(negedge clk);
    chk_pend("R8 sticky after idle");
    do_clr(128'h1 << 3);
    chk_pend("R9 clear t0 bit3");
    do_write(32'h0004_0005, 3'd0, 128'h1 << (2*NID + 5), "R9 set wins");
    chk_pend("R9 set wins pend");
    do_write(32'h0004_0005, 3'd0, 128'h1 << (2*NID + 5), "R9 set wins again");
    chk_pend("R9 pend held");
    do_clr({NT*NID{1'b1}});
    chk_pend("R9 clear all");
    do_write(32'h0180_0003, 3'd7, '0, "R3 others src7");
    chk_pend("R3 src7 pend");
    do_write(32'h0200_000C, 3'd0, '0, "R4 self src0");
    chk_pend("R4 src0 pend");
    repeat (4) @(negedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
    end
  end

endmodule